// File: doc/BRIEF.md
# Serial Bus Clock Divider

This block derives the timing of a two-wire serial bus clock from the system clock. A chain of programmable dividers produces a sampling-clock enable. A fixed ten-step phase counter then turns that enable into the bus clock: five sampling ticks low, five sampling ticks high. The bus clock therefore runs at f_sys / (2·(THP+1)) / 2^N / (M+1) / 10. THP is an 8-bit high-period count, M is a 4-bit divider and N is a 3-bit power-of-two exponent.

The byte controller uses the single-cycle enables `samp_en`, `scl_rise_en` and `scl_fall_en`. It never uses a derived clock. Software programs the factors with two 8-bit register writes. A write lands in a shadow copy, and the copy moves into the running divider only at the end of a bus-clock period, so a change never produces a runt pulse. A target that stretches the clock is reported on `scl_hold`. While `scl_hold` is asserted in the high phase, the phase count stops.

Top module: `sclk_divider`

## Requirements
- R1: After reset, `samp_en`, `scl_rise_en` and `scl_fall_en` are low and `scl_level` is low (start of the low phase). The active setting is THP=0x18, M=2, N=0, so the first `samp_en` comes 150 clock edges after reset is released.
- R2: `samp_en` is a one-cycle pulse that repeats every P = 2·(THP+1)·2^N·(M+1) clock cycles, where THP, M and N are the active values.
- R3: `scl_level` is low for 5 sampling ticks and high for 5 sampling ticks. One bus period is 10 ticks, and `scl_level` changes only after a rise or fall enable.
- R4: `scl_rise_en` is high in the `samp_en` cycle that ends the fifth low tick. `scl_fall_en` is high in the `samp_en` cycle that ends the fifth high tick. `scl_level` follows one cycle later.
- R5: A write with `cfg_sel`=0 loads THP from `cfg_wdata[7:0]`. A write with `cfg_sel`=1 loads M from `cfg_wdata[6:3]` and N from `cfg_wdata[2:0]`, and `cfg_wdata[7]` is ignored.
- R6: A written value becomes active only on the clock edge that ends a bus period, which is the cycle in which `scl_fall_en` is high. A write made in that same cycle waits for the following boundary.
- R7: While `scl_hold` is high during the high phase, the phase count stays put and no `scl_fall_en` is issued, but `samp_en` keeps its rate. `scl_hold` has no effect during the low phase.
- R8: The outputs are enables. `scl_rise_en` and `scl_fall_en` are never high together, and each is high only in a cycle where `samp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_sel | input | 1 | 0 selects the high-period register, 1 selects the M/N register |
| cfg_wdata | input | 8 | Write data |
| scl_hold | input | 1 | Bus clock is held low externally (clock stretching) |
| samp_en | output | 1 | Sampling-clock enable, ten per bus period |
| scl_rise_en | output | 1 | Enable for releasing the bus clock high |
| scl_fall_en | output | 1 | Enable for driving the bus clock low; marks the period boundary |
| scl_level | output | 1 | Level the bus clock should have (1 = high phase) |

## Verification
The checker assumes reset is applied before the first clock edge. It also assumes every period is at least two cycles long, which makes `samp_en` a single-cycle pulse; this holds for any 8-bit high-period count. Its boundary property assumes the active setting is read from the running divider, so it makes no assumption about when software writes. The stimulus programs only THP values from 5 upward and M values of 2 or more. It places writes both mid-period and near the boundary, and it releases `scl_hold` after a bounded time, so every scenario reaches further fall enables.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  localparam int DATA_W  = 8;
  localparam int THP_W   = 8;
  localparam int M_W     = 4;
  localparam int N_W     = 3;
  // counter width able to span 2^N - 1 for the largest N
  localparam int NCNT_W  = (1 << N_W) - 1;
  // clock-control field positions
  localparam int CTL_N_LSB = 0;
  localparam int CTL_M_LSB = N_W;

  typedef struct packed {
    logic [THP_W-1:0] thp;
    logic [M_W-1:0]   m;
    logic [N_W-1:0]   n;
  } div_cfg_t;

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
  import sclk_div_pkg::*;
#(
  parameter int RST_THP = 24,
  parameter int RST_M   = 2,
  parameter int RST_N   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output div_cfg_t          act
);

  localparam div_cfg_t RST_CFG = '{
    thp: THP_W'(RST_THP),
    m:   M_W'(RST_M),
    n:   N_W'(RST_N)
  };

  div_cfg_t shd;
  logic     unused_ctl_msb;

  assign unused_ctl_msb = wr_data[DATA_W-1];

  // shadow copy written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= RST_CFG;
    end else if (wr_en) begin
      if (!wr_sel) begin
        shd.thp <= wr_data[THP_W-1:0];
      end else begin
        shd.m <= wr_data[CTL_M_LSB +: M_W];
        shd.n <= wr_data[CTL_N_LSB +: N_W];
      end
    end
  end

  // running copy, moved only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= RST_CFG;
    end else if (load) begin
      act <= shd;
    end
  end

endmodule

// File: rtl/sclk_div_stage.sv
module sclk_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         wrap
);

  logic [W-1:0] cnt;

  assign wrap = step && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
  parameter int OS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic hold,
  output logic rise,
  output logic fall,
  output logic level
);

  localparam int PH_W = $clog2(OS);
  localparam int HALF = OS / 2;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF);

  logic [PH_W-1:0] ph;
  logic            adv;

  assign level = (ph >= PH_HIGH);
  // a stretched high phase stops the phase count
  assign adv   = samp && !(level && hold);
  assign rise  = adv && (ph == PH_RISE);
  assign fall  = adv && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (adv) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int OVERSAMPLE = 10,
  parameter int RST_THP    = 24,
  parameter int RST_M      = 2,
  parameter int RST_N      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              scl_hold,
  output logic              samp_en,
  output logic              scl_rise_en,
  output logic              scl_fall_en,
  output logic              scl_level
);

  div_cfg_t          cfg_act;
  logic              t_hp;
  logic              t_half;
  logic              t_pow;
  logic [NCNT_W-1:0] n_lim;

  sclk_cfg_regs #(
    .RST_THP(RST_THP),
    .RST_M  (RST_M),
    .RST_N  (RST_N)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_sel (cfg_sel),
    .wr_data(cfg_wdata),
    .load   (scl_fall_en),
    .act    (cfg_act)
  );

  // stage 1: high-period count, THP+1 cycles
  sclk_div_stage #(.W(THP_W)) u_hp (
    .clk  (clk),
    .rst_n(rst_n),
    .step (1'b1),
    .lim  (cfg_act.thp),
    .wrap (t_hp)
  );

  // fixed divide by two
  sclk_div_stage #(.W(1)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .step (t_hp),
    .lim  (1'b1),
    .wrap (t_half)
  );

  // stage 2: power-of-two divider, 2^N steps
  assign n_lim = ~({NCNT_W{1'b1}} << cfg_act.n);

  sclk_div_stage #(.W(NCNT_W)) u_pow (
    .clk  (clk),
    .rst_n(rst_n),
    .step (t_half),
    .lim  (n_lim),
    .wrap (t_pow)
  );

  // stage 3: M+1 divider gives the sampling tick
  sclk_div_stage #(.W(M_W)) u_mdiv (
    .clk  (clk),
    .rst_n(rst_n),
    .step (t_pow),
    .lim  (cfg_act.m),
    .wrap (samp_en)
  );

  sclk_phase_gen #(.OS(OVERSAMPLE)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .samp (samp_en),
    .hold (scl_hold),
    .rise (scl_rise_en),
    .fall (scl_fall_en),
    .level(scl_level)
  );

endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk
  import sclk_div_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     samp,
  input logic     rise,
  input logic     fall,
  input logic     level,
  input logic     hold,
  input div_cfg_t act
);

  AST_SAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    samp |=> !samp); // R2

  AST_EDGE_ON_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |-> samp); // R8

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall})); // R8

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> level); // R4

  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !level); // R4

  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise || fall) |=> $stable(level)); // R3

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (level && hold) |-> !fall); // R7

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(act)); // R6

endmodule

bind sclk_divider sclk_div_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .samp (samp_en),
  .rise (scl_rise_en),
  .fall (scl_fall_en),
  .level(scl_level),
  .hold (scl_hold),
  .act  (cfg_act)
);

// File: tb/tb_sclk_divider.sv
module tb_sclk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       scl_hold = 1'b0;
  logic       samp_en, scl_rise_en, scl_fall_en, scl_level;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  int q, ph;
  int thp_s, m_s, n_s, thp_a, m_a, n_a;
  int mp;
  bit msamp, madv;

  always #5 clk = ~clk;

  sclk_divider dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .scl_hold   (scl_hold),
    .samp_en    (samp_en),
    .scl_rise_en(scl_rise_en),
    .scl_fall_en(scl_fall_en),
    .scl_level  (scl_level)
  );

  function automatic int period();
    return 2 * (thp_a + 1) * (1 << n_a) * (m_a + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = 0; ph = 0;
      thp_s = 24; m_s = 2; n_s = 0;
      thp_a = 24; m_a = 2; n_a = 0;
    end else begin
      mp    = period();
      msamp = (q == mp - 1);
      madv  = msamp && !(ph >= 5 && scl_hold);
      if (madv && ph == 9) begin
        thp_a = thp_s; m_a = m_s; n_a = n_s;
      end
      if (cfg_we) begin
        if (!cfg_sel) thp_s = cfg_wdata;
        else begin
          m_s = (cfg_wdata >> 3) & 15;
          n_s = cfg_wdata & 7;
        end
      end
      q = msamp ? 0 : q + 1;
      if (madv) ph = (ph == 9) ? 0 : ph + 1;
    end
  end

  task automatic check_bit(string req, string name, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s got %b expected %b at %0t", req, tag, name, got, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check_bit("R1", "samp_en", samp_en, 1'b0);
        check_bit("R1", "scl_rise_en", scl_rise_en, 1'b0);
        check_bit("R1", "scl_fall_en", scl_fall_en, 1'b0);
        check_bit("R1", "scl_level", scl_level, 1'b0);
      end else begin
        automatic bit es = (q == period() - 1);
        automatic bit ea = es && !(ph >= 5 && scl_hold);
        check_bit("R2", "samp_en", samp_en, es);
        check_bit("R4/R8", "scl_rise_en", scl_rise_en, ea && ph == 4);
        check_bit("R4/R8", "scl_fall_en", scl_fall_en, ea && ph == 9);
        check_bit("R3", "scl_level", scl_level, ph >= 5);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(logic sel, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 defaults: first tick after 150 edges, full bus period 1500
    tag = "R1";
    idle(3200);

    // R6: mid-period write of the M/N register, M=3 N=1
    tag = "R6";
    idle(237);
    write_reg(1'b1, 8'h19);
    idle(9000);

    // R5: high-period write, then M/N write with bit 7 set (M=2 N=0)
    tag = "R5";
    write_reg(1'b0, 8'd7);
    write_reg(1'b1, 8'h90);
    idle(5000);

    // R6: write landing in the boundary cycle waits one more period
    tag = "R6";
    while (scl_fall_en !== 1'b1) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'd5;
    @(negedge clk);
    cfg_we = 1'b0;
    idle(2000);

    // R2: power-of-two stage, N=3 M=2
    tag = "R2";
    write_reg(1'b1, 8'h13);
    idle(9000);
    write_reg(1'b1, 8'h7A); // M=15 N=2
    write_reg(1'b0, 8'd5);
    idle(16000);
    write_reg(1'b1, 8'h10); // M=2 N=0
    idle(3000);

    // R7: hold during high phase freezes, during low phase has no effect
    tag = "R7";
    while (scl_level !== 1'b1) @(negedge clk);
    scl_hold = 1'b1;
    idle(400);
    scl_hold = 1'b0;
    idle(200);
    while (scl_level !== 1'b0) @(negedge clk);
    scl_hold = 1'b1;
    idle(150);
    scl_hold = 1'b0;
    idle(1200);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule